// File: doc/BRIEF.md
# I/O Port Permission Checker

This block decides whether a guest I/O port access must leave the guest and be handed to the host. A check starts with a single-cycle start strobe. The strobe carries the 16-bit port number, a parameter word whose bits 6:4 give the access size in bytes, the address of the next instruction, the base address of the permission bitmap, and the I/O intercept-enable bit.

When interception is enabled, the block fetches one 16-bit word from the bitmap through a request/valid read port. The word sits at byte address base + port/8. The block then tests one bitmap bit for each byte the access touches. These bits start at bit port mod 8 of the word, so an access that crosses a byte boundary of the bitmap is covered by that one unaligned read.

Every check ends with a one-cycle done strobe. When any tested bit is set, an exit strobe is raised at the same time and an exit record is presented: the exit code, exit info 1 (the parameter word with the port number placed at bit 16) and exit info 2 (the next-instruction address).

Top module: `ioperm_checker`

## Requirements
- R1: When the intercept-enable input is low at the start strobe, no bitmap read is requested. The check completes with done_o high in the cycle after the strobe and exit_o low.
- R2: When enabled, exactly one read is requested, at byte address base + port[15:3] (the port number divided by 8).
- R3: The byte count is n = param[6:4]. The tested bitmap bits are bits port[2:0] through port[2:0] + n − 1 of the returned 16-bit word. An exit fires if and only if at least one of those bits is 1.
- R4: A size field of 0 tests no bits, so no exit fires whatever the bitmap word holds.
- R5: The tested bits may run past bit 7 into the upper byte of the word, which holds the bitmap byte that follows. Set bits outside the tested range never cause an exit.
- R6: On an exit, exit_code_o is 0x07B, exit_info1_o is the zero-extended parameter word ORed with the port number shifted left by 16, and exit_info2_o is the next-instruction address.
- R7: done_o is high for exactly one cycle per accepted check. exit_o is high only together with done_o. When exit_o is low, exit_code_o, exit_info1_o and exit_info2_o are zero.
- R8: mem_req_o stays high with a stable mem_addr_o until mem_valid_i is seen, for any number of wait cycles. The result comes out in the cycle after mem_valid_i.
- R9: busy_o is high from the cycle after the start strobe until done_o. A start strobe while busy_o is high is ignored: the running check keeps its own operands and no second read or done follows.
- R10: After reset, busy_o, mem_req_o, done_o and exit_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe for a check |
| port_num_i | input | 16 | Accessed I/O port number |
| param_i | input | 32 | Access parameter word, size in bits 6:4 |
| next_ip_i | input | 64 | Address of the following instruction |
| bitmap_base_i | input | 64 | Byte address of the permission bitmap |
| io_icpt_en_i | input | 1 | I/O interception enabled |
| busy_o | output | 1 | A check is in progress |
| mem_req_o | output | 1 | Bitmap read request |
| mem_addr_o | output | 64 | Bitmap read byte address |
| mem_valid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 16 | Bitmap word, byte at mem_addr_o in bits 7:0 |
| done_o | output | 1 | Check complete (one cycle) |
| exit_o | output | 1 | Exit requested (one cycle, with done_o) |
| exit_code_o | output | 32 | Exit code |
| exit_info1_o | output | 64 | Parameter word with the port number at bit 16 |
| exit_info2_o | output | 64 | Next-instruction address |

## Verification
Bitmap words are chosen so that a single set bit inside the tested window is compared against its complement, which has every bit set except the tested ones. This separates a correct window from one that is shifted or one byte too wide. Accesses at offset 6 with four bytes put the only relevant bit in the upper byte, which catches a check that looks at a single byte. A size of zero against an all-ones word, and a disabled intercept against a read port that would answer, show that nothing is tested or fetched when it should not be. Wait states and a second start strobe during a pending read show that the request holds and that the running check keeps its own operands.

// File: rtl/ioperm_pkg.sv
package ioperm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_READ = 2'd1,
      ST_DONE = 2'd2
   } chk_state_t;

   localparam logic [31:0] IO_EXIT_CODE_DEF = 32'h0000_007B;

endpackage

// File: rtl/ioperm_mask_gen.sv
module ioperm_mask_gen #(
   parameter int OFF_W  = 3,
   parameter int SIZE_W = 3,
   parameter int MASK_W = 16
) (
   input  logic [OFF_W-1:0]  off_i,
   input  logic [SIZE_W-1:0] size_i,
   output logic [MASK_W-1:0] mask_o
);

   localparam int MAX_SPAN = (2 ** OFF_W - 1) + (2 ** SIZE_W - 1);

   if (MAX_SPAN > MASK_W) begin : g_bad_span
      $error("ioperm_mask_gen: window can exceed the fetched word");
   end

   // One comparator pair per bit: bit g is tested when off <= g < off + size
   for (genvar g = 0; g < MASK_W; g++) begin : g_bit
      assign mask_o[g] = (g >= int'(off_i)) && (g < (int'(off_i) + int'(size_i)));
   end

endmodule

// File: rtl/ioperm_ctrl.sv
module ioperm_ctrl
   import ioperm_pkg::*;
#(
   parameter int PORT_W  = 16,
   parameter int PARAM_W = 32,
   parameter int ADDR_W  = 64,
   parameter int DATA_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [PORT_W-1:0]  port_i,
   input  logic [PARAM_W-1:0] param_i,
   input  logic [ADDR_W-1:0]  nip_i,
   input  logic [ADDR_W-1:0]  base_i,
   input  logic               en_i,
   output logic               busy_o,
   output logic               mem_req_o,
   output logic [ADDR_W-1:0]  mem_addr_o,
   input  logic               mem_valid_i,
   input  logic [DATA_W-1:0]  mem_rdata_i,
   input  logic [DATA_W-1:0]  mask_i,
   output logic [PORT_W-1:0]  port_q_o,
   output logic [PARAM_W-1:0] param_q_o,
   output logic [ADDR_W-1:0]  nip_q_o,
   output logic               done_o,
   output logic               hit_o
);

   localparam int BYTE_SEL_W = PORT_W - 3;

   if (ADDR_W < BYTE_SEL_W) begin : g_bad_addr
      $error("ioperm_ctrl: address narrower than the byte index");
   end

   chk_state_t         state_q;
   logic [PORT_W-1:0]  port_q;
   logic [PARAM_W-1:0] param_q;
   logic [ADDR_W-1:0]  nip_q;
   logic [ADDR_W-1:0]  addr_q;
   logic               hit_q;
   logic               accept;
   logic [ADDR_W-1:0]  byte_idx;

   assign accept   = start_i && (state_q == ST_IDLE);
   assign byte_idx = {{(ADDR_W-BYTE_SEL_W){1'b0}}, port_i[PORT_W-1:3]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         port_q  <= '0;
         param_q <= '0;
         nip_q   <= '0;
         addr_q  <= '0;
         hit_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  port_q  <= port_i;
                  param_q <= param_i;
                  nip_q   <= nip_i;
                  addr_q  <= base_i + byte_idx;
                  hit_q   <= 1'b0;
                  state_q <= en_i ? ST_READ : ST_DONE;
               end
            end
            ST_READ: begin
               if (mem_valid_i) begin
                  hit_q   <= |(mem_rdata_i & mask_i);
                  state_q <= ST_DONE;
               end
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign busy_o     = (state_q != ST_IDLE);
   assign mem_req_o  = (state_q == ST_READ);
   assign mem_addr_o = addr_q;
   assign done_o     = (state_q == ST_DONE);
   assign hit_o      = hit_q && (state_q == ST_DONE);
   assign port_q_o   = port_q;
   assign param_q_o  = param_q;
   assign nip_q_o    = nip_q;

   // R1: a disabled check finishes without touching memory
   assert_no_read_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !en_i) |=> (!mem_req_o && done_o));

   // R8: request and address held while waiting
   assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

   // R7: done is a single-cycle pulse
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9: operands do not change while busy
   assert_operands_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> ($stable(port_q_o) && $stable(param_q_o) && $stable(nip_q_o)));

endmodule

// File: rtl/ioperm_exit_fmt.sv
module ioperm_exit_fmt #(
   parameter int          PORT_W     = 16,
   parameter int          PARAM_W    = 32,
   parameter int          INFO_W     = 64,
   parameter int          CODE_W     = 32,
   parameter int          PORT_SHIFT = 16,
   parameter logic [31:0] EXIT_CODE  = 32'h0000_007B
) (
   input  logic               hit_i,
   input  logic [PORT_W-1:0]  port_i,
   input  logic [PARAM_W-1:0] param_i,
   input  logic [INFO_W-1:0]  nip_i,
   output logic [CODE_W-1:0]  code_o,
   output logic [INFO_W-1:0]  info1_o,
   output logic [INFO_W-1:0]  info2_o
);

   if (INFO_W < PARAM_W || INFO_W < PORT_W + PORT_SHIFT) begin : g_bad_info
      $error("ioperm_exit_fmt: exit info too narrow");
   end
   if (CODE_W > 32) begin : g_bad_code
      $error("ioperm_exit_fmt: exit code wider than 32 bits");
   end

   logic [INFO_W-1:0] param_ext;
   logic [INFO_W-1:0] port_ext;

   assign param_ext = {{(INFO_W-PARAM_W){1'b0}}, param_i};
   assign port_ext  = {{(INFO_W-PORT_W){1'b0}}, port_i} << PORT_SHIFT;

   assign code_o  = hit_i ? EXIT_CODE[CODE_W-1:0] : '0;
   assign info1_o = hit_i ? (param_ext | port_ext) : '0;
   assign info2_o = hit_i ? nip_i : '0;

endmodule

// File: rtl/ioperm_checker.sv
module ioperm_checker
   import ioperm_pkg::*;
#(
   parameter int          PORT_W     = 16,
   parameter int          PARAM_W    = 32,
   parameter int          ADDR_W     = 64,
   parameter int          DATA_W     = 16,
   parameter int          CODE_W     = 32,
   parameter int          SIZE_LSB   = 4,
   parameter int          SIZE_W     = 3,
   parameter int          PORT_SHIFT = 16,
   parameter logic [31:0] EXIT_CODE  = IO_EXIT_CODE_DEF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [PORT_W-1:0]  port_num_i,
   input  logic [PARAM_W-1:0] param_i,
   input  logic [ADDR_W-1:0]  next_ip_i,
   input  logic [ADDR_W-1:0]  bitmap_base_i,
   input  logic               io_icpt_en_i,
   output logic               busy_o,
   output logic               mem_req_o,
   output logic [ADDR_W-1:0]  mem_addr_o,
   input  logic               mem_valid_i,
   input  logic [DATA_W-1:0]  mem_rdata_i,
   output logic               done_o,
   output logic               exit_o,
   output logic [CODE_W-1:0]  exit_code_o,
   output logic [ADDR_W-1:0]  exit_info1_o,
   output logic [ADDR_W-1:0]  exit_info2_o
);

   localparam int OFF_W = 3;

   if (SIZE_LSB + SIZE_W > PARAM_W) begin : g_bad_size
      $error("ioperm_checker: size field outside the parameter word");
   end
   if (PORT_W <= OFF_W) begin : g_bad_port
      $error("ioperm_checker: port number too narrow");
   end

   logic [PORT_W-1:0]  port_q;
   logic [PARAM_W-1:0] param_q;
   logic [ADDR_W-1:0]  nip_q;
   logic [DATA_W-1:0]  mask;
   logic               hit;

   ioperm_ctrl #(
      .PORT_W (PORT_W),
      .PARAM_W(PARAM_W),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .port_i     (port_num_i),
      .param_i    (param_i),
      .nip_i      (next_ip_i),
      .base_i     (bitmap_base_i),
      .en_i       (io_icpt_en_i),
      .busy_o     (busy_o),
      .mem_req_o  (mem_req_o),
      .mem_addr_o (mem_addr_o),
      .mem_valid_i(mem_valid_i),
      .mem_rdata_i(mem_rdata_i),
      .mask_i     (mask),
      .port_q_o   (port_q),
      .param_q_o  (param_q),
      .nip_q_o    (nip_q),
      .done_o     (done_o),
      .hit_o      (hit)
   );

   ioperm_mask_gen #(
      .OFF_W (OFF_W),
      .SIZE_W(SIZE_W),
      .MASK_W(DATA_W)
   ) u_mask (
      .off_i (port_q[OFF_W-1:0]),
      .size_i(param_q[SIZE_LSB +: SIZE_W]),
      .mask_o(mask)
   );

   ioperm_exit_fmt #(
      .PORT_W    (PORT_W),
      .PARAM_W   (PARAM_W),
      .INFO_W    (ADDR_W),
      .CODE_W    (CODE_W),
      .PORT_SHIFT(PORT_SHIFT),
      .EXIT_CODE (EXIT_CODE)
   ) u_fmt (
      .hit_i  (hit),
      .port_i (port_q),
      .param_i(param_q),
      .nip_i  (nip_q),
      .code_o (exit_code_o),
      .info1_o(exit_info1_o),
      .info2_o(exit_info2_o)
   );

   assign exit_o = hit;

   // R7: exit only alongside done, record zero otherwise
   assert_exit_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      exit_o |-> done_o);
   assert_idle_record_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !exit_o |-> (exit_info1_o == '0 && exit_info2_o == '0 && exit_code_o == '0));

   // R4: a zero-length access never exits
   assert_zero_size_no_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && param_q[SIZE_LSB +: SIZE_W] == '0) |-> !exit_o);

   // R9: busy covers the whole check
   assert_busy_with_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o || done_o) |-> busy_o);

endmodule

// File: tb/ioperm_checker_bench.sv
`timescale 1ns/1ps
module ioperm_checker_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [15:0] port_num_i = '0;
   logic [31:0] param_i = '0;
   logic [63:0] next_ip_i = '0;
   logic [63:0] bitmap_base_i = '0;
   logic        io_icpt_en_i = 1'b0;
   logic        busy_o, mem_req_o, done_o, exit_o;
   logic [63:0] mem_addr_o, exit_info1_o, exit_info2_o;
   logic        mem_valid_i = 1'b0;
   logic [15:0] mem_rdata_i = '0;
   logic [31:0] exit_code_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   ioperm_checker u_ioperm_checker (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .port_num_i(port_num_i),
      .param_i(param_i), .next_ip_i(next_ip_i), .bitmap_base_i(bitmap_base_i),
      .io_icpt_en_i(io_icpt_en_i), .busy_o(busy_o), .mem_req_o(mem_req_o),
      .mem_addr_o(mem_addr_o), .mem_valid_i(mem_valid_i), .mem_rdata_i(mem_rdata_i),
      .done_o(done_o), .exit_o(exit_o), .exit_code_o(exit_code_o),
      .exit_info1_o(exit_info1_o), .exit_info2_o(exit_info2_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // One complete check; expected values derived from the requirement text
   task automatic run_check(input string req, input logic [15:0] port,
                            input logic [31:0] param, input logic [63:0] nip,
                            input logic [63:0] base, input logic en,
                            input logic [15:0] word, input int lat,
                            input bit poke_busy);
      int n;
      logic hit;
      logic [63:0] e1;
      n = int'(param[6:4]);
      hit = 1'b0;
      for (int b = 0; b < n; b++)
         if (word[int'(port[2:0]) + b]) hit = 1'b1;
      hit = hit && en;
      e1 = {32'd0, param} | ({48'd0, port} << 16);

      @(negedge clk);
      start_i = 1'b1; port_num_i = port; param_i = param;
      next_ip_i = nip; bitmap_base_i = base; io_icpt_en_i = en;
      @(negedge clk);
      start_i = 1'b0;
      chk(req, "busy after start", {63'd0, busy_o}, 64'd1);
      if (en) begin
         chk({req, "/R2"}, "read request", {63'd0, mem_req_o}, 64'd1);
         chk({req, "/R2"}, "read address", mem_addr_o, base + {51'd0, port[15:3]});
         for (int w = 0; w < lat; w++) begin
            if (poke_busy && w == 0) begin
               start_i = 1'b1; port_num_i = port ^ 16'h0F0F;
               param_i = 32'h0000_0070; next_ip_i = 64'hDEAD;
            end
            @(negedge clk);
            start_i = 1'b0;
            chk({req, "/R8"}, "request held", {63'd0, mem_req_o}, 64'd1);
            chk({req, "/R8"}, "address held", mem_addr_o, base + {51'd0, port[15:3]});
            chk({req, "/R8"}, "no early done", {63'd0, done_o}, 64'd0);
         end
         mem_valid_i = 1'b1; mem_rdata_i = word;
         @(negedge clk);
         mem_valid_i = 1'b0; mem_rdata_i = '0;
      end else begin
         chk({req, "/R1"}, "no read when disabled", {63'd0, mem_req_o}, 64'd0);
      end
      chk({req, "/R7"}, "done pulse", {63'd0, done_o}, 64'd1);
      chk({req, "/R3"}, "exit decision", {63'd0, exit_o}, {63'd0, hit});
      chk({req, "/R6"}, "exit code", {32'd0, exit_code_o}, hit ? 64'h7B : 64'd0);
      chk({req, "/R6"}, "exit info1", exit_info1_o, hit ? e1 : 64'd0);
      chk({req, "/R6"}, "exit info2", exit_info2_o, hit ? nip : 64'd0);
      @(negedge clk);
      chk({req, "/R7"}, "done drops", {63'd0, done_o}, 64'd0);
      chk({req, "/R9"}, "idle after done", {62'd0, busy_o, mem_req_o}, 64'd0);
   endtask

   task automatic t_reset;
      chk("R10", "reset outputs", {60'd0, busy_o, mem_req_o, done_o, exit_o}, 64'd0);
   endtask

   task automatic t_disabled;
      run_check("R1", 16'h0123, 32'h0000_0010, 64'h1000, 64'h8000, 1'b0, 16'hFFFF, 0, 0);
   endtask

   task automatic t_single_byte;
      run_check("R3", 16'h0123, 32'h0000_0011, 64'h0000_0040_0000_1234,
                64'h0000_0001_0000_0000, 1'b1, 16'h0008, 0, 0);
      run_check("R3", 16'h0123, 32'h0000_0011, 64'h1234, 64'h8000, 1'b1, 16'hFFF7, 0, 0);
   endtask

   task automatic t_span;
      run_check("R5", 16'h03F6, 32'h0000_0040, 64'h2222, 64'h0_4000, 1'b1, 16'h0200, 1, 0);
      run_check("R5", 16'h03F6, 32'h0000_0040, 64'h2222, 64'h0_4000, 1'b1, 16'hFC3F, 1, 0);
   endtask

   task automatic t_size_zero;
      run_check("R4", 16'hFFFF, 32'h0000_0008, 64'h3333, 64'h0, 1'b1, 16'hFFFF, 0, 0);
   endtask

   task automatic t_wait;
      run_check("R8", 16'h0080, 32'hABCD_0020, 64'h4444, 64'hF000, 1'b1, 16'h0002, 5, 0);
   endtask

   task automatic t_busy;
      run_check("R9", 16'h1235, 32'h0000_0010, 64'h5555, 64'h100, 1'b1, 16'h0020, 3, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_disabled();
      t_single_byte();
      t_span();
      t_size_zero();
      t_wait();
      t_busy();
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule